// File: doc/BRIEF.md
# I2C Clock-Phase Timer

This block produces the serial clock for an I2C master and marks the instants at which the byte engine may move the data line. It runs from a fast internal clock. Four programmable counts, all measured in internal clock cycles, set its timing: the nominal bus period, the length of the driven-low phase, the setup delay before a repeated START or STOP, and the data setup margin before the clock is released. The block drives SCL low through an open-drain enable. It watches the real line level, so a target that holds SCL low (clock stretching) delays the high phase.

For a 50 MHz internal clock, software sets the period count to 50 000 000 divided by the bus rate, with 400 kHz as the fastest supported rate. The low count and the repeated-START/STOP setup count are each half the period count, and the data setup count is one sixteenth of it. Two control bits manage the block. With `ctl_release` low, SCL is forced low. With `ctl_release` high and `ctl_run` low, the bus sits idle with SCL released, and the counts can safely be changed. With both bits high, clocking runs.

States: IDLE (released, counts tracked), HOLD (SCL forced low), LOW (SCL driven low, low counter running), WAIT (SCL released, waiting to read it high), HIGH (high counter running). Transitions:
- START: IDLE to LOW when running is enabled.
- LOW_DONE: LOW to WAIT when the low count expires.
- SEEN_HIGH: WAIT to HIGH when SCL reads high.
- NEXT: HIGH to LOW when the high count expires and running is still enabled.
- STOP: HIGH to IDLE when the high count expires and running is disabled.
- HOLD_ENTER: any state to HOLD when release is low.
- HOLD_EXIT: HOLD to IDLE when release returns high.

In the requirements below, the effective value of a count is the count itself, or 1 when the count is zero. Lc is the effective low count, Pc the effective period count, Sc the effective START/STOP setup count and Dc the effective data setup count. The high length is Hc = Pc-Lc-1 when Pc > Lc+1, and 1 otherwise.

Top module: `i2c_scl_timer`

## Requirements
- R1: During reset and after it, with `ctl_run` low and `ctl_release` high, `scl_oe` is 0 and neither tick is asserted.
- R2: When `ctl_release` is low at a clock edge, `scl_oe` is 1 from the next cycle on and no tick is asserted. One cycle after `ctl_release` returns high, `scl_oe` is 0 again (if `ctl_run` is low).
- R3: In IDLE with both control bits high, `scl_oe` becomes 1 in the next cycle and stays 1 for exactly Lc cycles.
- R4: A zero in any of the four counts acts as a count of one.
- R5: `sda_tick` pulses exactly once in each low phase, at cycle index Lc-Dc counted from 0 at the first low cycle, or at index 0 when Dc >= Lc. It is only ever asserted while `scl_oe` is 1.
- R6: After the low phase, `scl_oe` stays 0, and the block waits without counting for as long as `scl_in` reads 0 (clock stretching).
- R7: Counting from the cycle in which `scl_in` is first seen high, SCL remains released for 1+Hc cycles before the next low phase. Without stretching, a full cycle is therefore Lc+1+Hc cycles, which equals Pc for ordinary settings.
- R8: `cond_tick` pulses once per high phase, min(Sc,Hc) cycles after the cycle in which SCL was first seen high, and only while SCL is released and reads high.
- R9: The counts are captured only in IDLE and HOLD. Changing them while clocking has no effect on the running timing.
- R10: When `ctl_run` goes low during clocking, the current high phase completes. The block then returns to IDLE with SCL released, and no further ticks appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal timing clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_run | input | 1 | Normal-operation enable |
| ctl_release | input | 1 | Release the forced-low hold on SCL |
| cfg_period | input | CW | Nominal bus period in clock cycles |
| cfg_low | input | CW | SCL low phase in clock cycles |
| cfg_cond_setup | input | CW | Setup before repeated START/STOP |
| cfg_data_setup | input | CW | SDA setup before SCL release |
| scl_in | input | 1 | Sampled SCL line level |
| scl_oe | output | 1 | Drive SCL low when 1 |
| sda_tick | output | 1 | Data line may change this cycle |
| cond_tick | output | 1 | START/STOP setup reached this cycle |

## Verification
The bench builds the block with the default 16-bit count width. This leaves room for settings from all-zero counts up to periods of several dozen cycles. The vector settings place the data setup beyond the low phase and the START/STOP setup beyond the high phase, so the clamped timing paths are exercised. They also set the period below low-plus-one and include stretches of up to three cycles, so the minimum high phase and the stretch wait are reached.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_HOLD = 3'd1,
        ST_LOW  = 3'd2,
        ST_WAIT = 3'd3,
        ST_HIGH = 3'd4
    } i2ct_state_e;

    localparam int NUM_COUNTS = 4;
    localparam int IDX_PERIOD = 0;
    localparam int IDX_LOW    = 1;
    localparam int IDX_COND   = 2;
    localparam int IDX_DATA   = 3;

endpackage

// File: rtl/i2ct_shadow.sv
module i2ct_shadow
    import i2ct_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] period_i,
    input  logic [CW-1:0] low_i,
    input  logic [CW-1:0] cond_i,
    input  logic [CW-1:0] data_i,
    output logic [CW-1:0] low_len,
    output logic [CW-1:0] high_len,
    output logic [CW-1:0] sda_at,
    output logic [CW-1:0] cond_at
);

    localparam int XW = CW + 1;

    logic [NUM_COUNTS-1:0][CW-1:0] raw_in;
    logic [NUM_COUNTS-1:0][CW-1:0] raw_q;
    logic [NUM_COUNTS-1:0][CW-1:0] eff;

    assign raw_in[IDX_PERIOD] = period_i;
    assign raw_in[IDX_LOW]    = low_i;
    assign raw_in[IDX_COND]   = cond_i;
    assign raw_in[IDX_DATA]   = data_i;

    // Counts are captured only while the bus is parked.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q <= '0;
        end else if (load) begin
            raw_q <= raw_in;
        end
    end

    // Zero is treated as a single cycle.
    for (genvar g = 0; g < NUM_COUNTS; g++) begin : g_clamp
        assign eff[g] = (raw_q[g] == '0) ? CW'(1) : raw_q[g];
    end

    logic [XW-1:0] pv, lv, hv_x;
    logic [CW-1:0] sv, dv, hv;

    assign pv = {1'b0, eff[IDX_PERIOD]};
    assign lv = {1'b0, eff[IDX_LOW]};
    assign sv = eff[IDX_COND];
    assign dv = eff[IDX_DATA];

    always_comb begin
        if (pv > lv + XW'(1)) begin
            hv_x = pv - lv - XW'(1);
        end else begin
            hv_x = XW'(1);
        end
        hv = hv_x[CW-1:0];
    end

    assign low_len  = eff[IDX_LOW];
    assign high_len = hv;
    assign sda_at   = (dv >= eff[IDX_LOW]) ? '0 : eff[IDX_LOW] - dv;
    assign cond_at  = ((sv < hv) ? sv : hv) - CW'(1);

endmodule

// File: rtl/i2ct_phase_cnt.sv
module i2ct_phase_cnt #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [CW-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

endmodule

// File: rtl/i2ct_fsm.sv
module i2ct_fsm
    import i2ct_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_run,
    input  logic          ctl_release,
    input  logic          scl_in,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] low_len,
    input  logic [CW-1:0] high_len,
    input  logic [CW-1:0] sda_at,
    input  logic [CW-1:0] cond_at,
    output logic          cnt_clr,
    output logic          shadow_load,
    output logic          scl_oe,
    output logic          sda_tick,
    output logic          cond_tick
);

    i2ct_state_e state_q, state_d;

    logic low_last, high_last;
    assign low_last  = (cnt == low_len - CW'(1));
    assign high_last = (cnt == high_len - CW'(1));

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (ctl_run) state_d = ST_LOW;        // START
            ST_HOLD: state_d = ST_IDLE;                    // HOLD_EXIT
            ST_LOW:  if (low_last) state_d = ST_WAIT;      // LOW_DONE
            ST_WAIT: if (scl_in) state_d = ST_HIGH;        // SEEN_HIGH
            ST_HIGH: if (high_last) begin
                state_d = ctl_run ? ST_LOW : ST_IDLE;      // NEXT / STOP
            end
            default: state_d = ST_IDLE;
        endcase
        if (!ctl_release) begin
            state_d = ST_HOLD;                             // HOLD_ENTER
        end
    end

    // Outputs.
    always_comb begin
        scl_oe      = (state_q == ST_LOW) || (state_q == ST_HOLD);
        sda_tick    = (state_q == ST_LOW) && (cnt == sda_at);
        cond_tick   = (state_q == ST_HIGH) && (cnt == cond_at);
        shadow_load = (state_q == ST_IDLE) || (state_q == ST_HOLD);
        cnt_clr     = (state_d != state_q);
    end

endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_run,
    input  logic          ctl_release,
    input  logic [CW-1:0] cfg_period,
    input  logic [CW-1:0] cfg_low,
    input  logic [CW-1:0] cfg_cond_setup,
    input  logic [CW-1:0] cfg_data_setup,
    input  logic          scl_in,
    output logic          scl_oe,
    output logic          sda_tick,
    output logic          cond_tick
);

    logic [CW-1:0] cnt, low_len, high_len, sda_at, cond_at;
    logic          cnt_clr, shadow_load;

    i2ct_shadow #(.CW(CW)) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (shadow_load),
        .period_i (cfg_period),
        .low_i    (cfg_low),
        .cond_i   (cfg_cond_setup),
        .data_i   (cfg_data_setup),
        .low_len  (low_len),
        .high_len (high_len),
        .sda_at   (sda_at),
        .cond_at  (cond_at)
    );

    i2ct_phase_cnt #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .cnt   (cnt)
    );

    i2ct_fsm #(.CW(CW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_run     (ctl_run),
        .ctl_release (ctl_release),
        .scl_in      (scl_in),
        .cnt         (cnt),
        .low_len     (low_len),
        .high_len    (high_len),
        .sda_at      (sda_at),
        .cond_at     (cond_at),
        .cnt_clr     (cnt_clr),
        .shadow_load (shadow_load),
        .scl_oe      (scl_oe),
        .sda_tick    (sda_tick),
        .cond_tick   (cond_tick)
    );

endmodule

// File: rtl/i2c_scl_timer_chk.sv
module i2c_scl_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic ctl_release,
    input logic scl_in,
    input logic scl_oe,
    input logic sda_tick,
    input logic cond_tick
);

    a_r5_sda_while_low: assert property (@(posedge clk) disable iff (!rst_n)
        sda_tick |-> scl_oe);

    a_r8_cond_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        cond_tick |-> (!scl_oe && scl_in));

    a_r2_hold_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_release |=> scl_oe);

    a_r2_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_release && $past(!ctl_release)) |-> (!sda_tick && !cond_tick));

    a_r5_r8_one_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sda_tick, cond_tick}));

endmodule

bind i2c_scl_timer i2c_scl_timer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_release (ctl_release),
    .scl_in      (scl_in),
    .scl_oe      (scl_oe),
    .sda_tick    (sda_tick),
    .cond_tick   (cond_tick)
);

// File: tb/i2c_scl_timer_tb.sv
module i2c_scl_timer_tb;

    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_run = 1'b0;
    logic ctl_release = 1'b1;
    logic stretch = 1'b0;
    logic [W-1:0] c_per = '0, c_low = '0, c_cs = '0, c_ds = '0;
    logic scl_in, scl_oe, sda_tick, cond_tick;

    assign scl_in = !scl_oe && !stretch;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    i2c_scl_timer #(.CW(W)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .ctl_run        (ctl_run),
        .ctl_release    (ctl_release),
        .cfg_period     (c_per),
        .cfg_low        (c_low),
        .cfg_cond_setup (c_cs),
        .cfg_data_setup (c_ds),
        .scl_in         (scl_in),
        .scl_oe         (scl_oe),
        .sda_tick       (sda_tick),
        .cond_tick      (cond_tick)
    );

    // period, low, cond setup, data setup, stretch cycles
    localparam int NV = 5;
    localparam int VEC [NV][5] = '{
        '{20, 10, 10, 2, 0},
        '{12,  4,  3, 1, 2},
        '{ 0,  0,  0, 0, 0},
        '{ 8,  6,  5, 9, 1},
        '{30, 15,  4, 0, 3}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff(input int x);
        return (x == 0) ? 1 : x;
    endfunction

    function automatic int exp_high(input int p, input int l);
        return (eff(p) > eff(l) + 1) ? eff(p) - eff(l) - 1 : 1;
    endfunction

    int m_low, m_sda_idx, m_sda_cnt, m_high, m_cond_idx, m_cond_cnt;

    // Called at a negedge; measures one low phase and the following released phase.
    task automatic run_period(input int k, input bit last);
        int guard = 0;
        int limit;
        limit = last ? 300 : 5000;
        while (!scl_oe && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        m_low = 0; m_sda_idx = -1; m_sda_cnt = 0;
        while (scl_oe && m_low < 1000) begin
            if (sda_tick) begin
                m_sda_idx = m_low;
                m_sda_cnt++;
            end
            m_low++;
            @(negedge clk);
        end
        if (last) ctl_run = 1'b0;
        stretch = (k > 0);
        m_high = 0; m_cond_idx = -1; m_cond_cnt = 0;
        while (!scl_oe && m_high < limit) begin
            if (m_high == k) stretch = 1'b0;
            if (cond_tick) begin
                m_cond_idx = m_high;
                m_cond_cnt++;
            end
            m_high++;
            @(negedge clk);
        end
        stretch = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(scl_oe == 1'b0, "R1 oe in reset", int'(scl_oe), 0);
        chk(!sda_tick && !cond_tick, "R1 ticks in reset", int'(sda_tick | cond_tick), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(scl_oe == 1'b0, "R1 oe idle", int'(scl_oe), 0);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            int el, eh, esda, econd, k;
            c_per = W'(VEC[v][0]); c_low = W'(VEC[v][1]);
            c_cs = W'(VEC[v][2]); c_ds = W'(VEC[v][3]);
            k = VEC[v][4];
            el = eff(VEC[v][1]);
            eh = exp_high(VEC[v][0], VEC[v][1]);
            esda = (eff(VEC[v][3]) >= el) ? 0 : el - eff(VEC[v][3]);
            econd = k + ((eff(VEC[v][2]) < eh) ? eff(VEC[v][2]) : eh);
            ctl_run = 1'b1;
            @(negedge clk);
            for (int p = 0; p < 2; p++) begin
                run_period(k, p == 1);
                if (v == 2) chk(m_low == el, "R4 low of zero count", m_low, el);
                else        chk(m_low == el, "R3 low length", m_low, el);
                chk(m_sda_idx == esda, "R5 sda position", m_sda_idx, esda);
                chk(m_sda_cnt == 1, "R5 sda once", m_sda_cnt, 1);
                chk(m_cond_idx == econd, "R8 cond position", m_cond_idx, econd);
                chk(m_cond_cnt == 1, "R8 cond once", m_cond_cnt, 1);
                if (p == 0) begin
                    if (k > 0) chk(m_high == k + 1 + eh, "R6 stretched high", m_high, k + 1 + eh);
                    else       chk(m_high == 1 + eh, "R7 high length", m_high, 1 + eh);
                end else begin
                    chk(m_high == 300, "R10 idle after stop", m_high, 300);
                end
            end
        end

        // R2: hold from idle
        ctl_release = 1'b0;
        @(negedge clk);
        chk(scl_oe == 1'b1, "R2 hold from idle", int'(scl_oe), 1);
        repeat (5) begin
            @(negedge clk);
            chk(scl_oe && !sda_tick && !cond_tick, "R2 hold steady", int'(scl_oe), 1);
        end
        ctl_release = 1'b1;
        @(negedge clk);
        chk(scl_oe == 1'b0, "R2 released", int'(scl_oe), 0);

        // R2: hold while clocking
        c_per = W'(20); c_low = W'(10); c_cs = W'(3); c_ds = W'(2);
        ctl_run = 1'b1;
        repeat (15) @(negedge clk);
        ctl_release = 1'b0;
        ctl_run = 1'b0;
        @(negedge clk);
        chk(scl_oe == 1'b1, "R2 hold mid-run", int'(scl_oe), 1);
        ctl_release = 1'b1;
        @(negedge clk);
        chk(scl_oe == 1'b0, "R2 release mid-run", int'(scl_oe), 0);
        repeat (3) @(negedge clk);

        // R9: counts changed while clocking are ignored
        c_per = W'(12); c_low = W'(5); c_cs = W'(2); c_ds = W'(1);
        ctl_run = 1'b1;
        @(negedge clk);
        c_low = W'(2); c_per = W'(40);
        run_period(0, 1'b0);
        chk(m_low == 5, "R9 first low unchanged", m_low, 5);
        chk(m_high == 1 + 6, "R9 high unchanged", m_high, 7);
        run_period(0, 1'b1);
        chk(m_low == 5, "R9 second low unchanged", m_low, 5);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule